// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped controller for a bank of general-purpose pins. The pin count is a parameter and may be 64 or 96. It holds three kinds of state for each pin: whether the pin drives, the value it drives, and a two-bit alternate-function selector. It drives the pad output and output-enable buses from that state. It also samples the pad inputs through a two-flop synchronizer so that they can be read back.

Software reaches the controller through a plain 32-bit register interface. There are separate write and read strobes, and a read returns its data one cycle after it is issued. Registers are grouped by kind. Each kind takes one 32-bit word for every 32 pins, so the spacing between kinds grows with the pin count. The output latch is changed through two registers: one sets bits when a 1 is written, the other clears them. A read-modify-write is therefore never needed to change one pin.

The rising-enable, falling-enable and edge-status words are decoded here but stored in a companion interrupt block. This block forwards strobes, the kind and the word index to that block, and returns its read data.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is an input (padOe all 0), every output latch is 0 (padOut all 0), every alternate-function field is 0 (altSel all 0), and all register reads return 0 except the level register.
- R2: With W = PIN_COUNT/32, word k of register kind t sits at byte address t·W·4 + k·4. The kind order is 0 level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge-status, 7 alternate-function. Pin p of a one-bit-per-pin kind is bit p mod 32 of word p/32.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. The direction word reads back as written, padOe follows it one cycle after the write, and the direction changes only on a direction write.
- R4: Writing the set register drives to 1 every latch whose data bit is 1 and leaves latches with data bit 0 unchanged. padOut shows the result one cycle after the write.
- R5: Writing the clear register drives to 0 every latch whose data bit is 1 and leaves latches with data bit 0 unchanged.
- R6: Reads of the set and clear registers return 0.
- R7: The level register returns the pad inputs through a two-flop synchronizer. A read issued in the same cycle as an input change returns the old level, and a read issued two cycles later returns the new level. Writes to the level register are ignored.
- R8: The alternate-function kind holds 2 bits per pin in 2·W words that start at the kind-7 base. Pin p uses bits (p mod 16)·2+1 : (p mod 16)·2 of word p/16, and these bits also appear at altSel[2p+1:2p]. Field value 0 means plain GPIO. The words read back as written.
- R9: An access to kinds 4, 5 or 6 raises extWrStb or extRdStb in the same cycle, together with extType (0 rising, 1 falling, 2 status) and extWord = k. A read of these kinds returns extRdData. extWrStb is never raised without busWrEn.
- R10: An address with nonzero low two bits, or a word address at or beyond 9·W, reads 0, and a write to it changes no state.
- R11: busRdData takes its new value in the cycle after busRdEn and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| padIn | input | PIN_COUNT | Asynchronous pad input levels |
| padOut | output | PIN_COUNT | Output latch values to the pads |
| padOe | output | PIN_COUNT | Pad output enables (1 = drive) |
| altSel | output | 2*PIN_COUNT | Alternate-function field per pin |
| extWrStb | output | 1 | Write to an interrupt-block word |
| extRdStb | output | 1 | Read from an interrupt-block word |
| extType | output | 2 | Interrupt-block kind: 0 rising, 1 falling, 2 status |
| extWord | output | WIDX_W | Word index within the interrupt-block kind |
| extRdData | input | 32 | Read data returned by the interrupt block |

## Verification
Register writes show on padOe, padOut and altSel one clock after the write strobe. Read data shows one clock after the read strobe. Level changes need two clock edges to pass the synchronizer. The interrupt-block strobes are combinational and are due in the same cycle as the access. The bench drives every stimulus on a falling edge and samples on a later falling edge, placed by counting those registers, so each result is checked in the first cycle it is due. The synchronizer check issues a read together with the input change, expects the old level, and then repeats the read two cycles later.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Source selected for the registered read data
  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_LEVEL = 3'd1,
    SRC_DIR   = 3'd2,
    SRC_ALT   = 3'd3,
    SRC_EXT   = 3'd4
  } rdSrc_e;

  // Strobes from the address decode to the datapath
  typedef struct packed {
    logic   wrDir;
    logic   wrSet;
    logic   wrClr;
    logic   wrAlt;
    logic   rdEn;
    rdSrc_e rdSrc;
    logic [7:0] word;
  } ctrlStb_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int WORDS  = 3,
  parameter int ADDR_W = 8,
  parameter int WIDX_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStb_t          ctrl,
  output logic              extWrStb,
  output logic              extRdStb,
  output logic [1:0]        extType,
  output logic [WIDX_W-1:0] extWord
);

  localparam int ALT_LO = 7 * WORDS;
  localparam int ALT_HI = 9 * WORDS;

  logic [31:0] waInt;
  logic [31:0] kindIdx;
  logic [31:0] wordIdx;
  logic        aligned;
  logic        extHit;

  always_comb begin
    waInt   = 32'(busAddr[ADDR_W-1:2]);
    aligned = (busAddr[1:0] == 2'b00);
    kindIdx = waInt / WORDS;
    wordIdx = waInt % WORDS;

    ctrl       = '0;
    ctrl.rdSrc = SRC_NONE;
    ctrl.rdEn  = busRdEn;
    extHit     = 1'b0;
    extType    = 2'd0;

    if (aligned && waInt >= ALT_LO && waInt < ALT_HI) begin
      // alternate-function kind spans twice the normal stride
      ctrl.wrAlt = busWrEn;
      ctrl.rdSrc = SRC_ALT;
      ctrl.word  = 8'(waInt - ALT_LO);
    end else if (aligned && waInt < ALT_LO) begin
      ctrl.word = 8'(wordIdx);
      case (kindIdx)
        32'd0: ctrl.rdSrc = SRC_LEVEL;
        32'd1: begin
          ctrl.wrDir = busWrEn;
          ctrl.rdSrc = SRC_DIR;
        end
        32'd2: ctrl.wrSet = busWrEn;
        32'd3: ctrl.wrClr = busWrEn;
        32'd4, 32'd5, 32'd6: begin
          extHit     = 1'b1;
          ctrl.rdSrc = SRC_EXT;
          extType    = 2'(kindIdx - 32'd4);
        end
        default: ctrl.rdSrc = SRC_NONE;
      endcase
    end
  end

  assign extWrStb = extHit & busWrEn;
  assign extRdStb = extHit & busRdEn;
  assign extWord  = WIDX_W'(wordIdx);

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 96
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStb_t               ctrl,
  input  logic [31:0]            busWrData,
  input  logic [31:0]            extRdData,
  input  logic [PIN_COUNT-1:0]   padIn,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic [2*PIN_COUNT-1:0] altSel,
  output logic [31:0]            busRdData
);

  localparam int WORDS     = PIN_COUNT / 32;
  localparam int ALT_WORDS = 2 * WORDS;

  logic [PIN_COUNT-1:0]   dirReg;
  logic [PIN_COUNT-1:0]   outReg;
  logic [2*PIN_COUNT-1:0] altReg;
  logic [PIN_COUNT-1:0]   syncA;
  logic [PIN_COUNT-1:0]   syncB;
  logic [31:0]            rdNext;
  logic [31:0]            rdReg;

  // two-flop input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // one-bit-per-pin words
  for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirReg[gw*32 +: 32] <= '0;
        outReg[gw*32 +: 32] <= '0;
      end else if (ctrl.word == 8'(gw)) begin
        if (ctrl.wrDir) dirReg[gw*32 +: 32] <= busWrData;
        if (ctrl.wrSet) outReg[gw*32 +: 32] <= outReg[gw*32 +: 32] | busWrData;
        if (ctrl.wrClr) outReg[gw*32 +: 32] <= outReg[gw*32 +: 32] & ~busWrData;
      end
    end

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.wrSet && ctrl.word == 8'(gw)) |=>
        ((outReg[gw*32 +: 32] & $past(busWrData)) == $past(busWrData))); // R4
    AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.wrSet && ctrl.word == 8'(gw)) |=>
        ((outReg[gw*32 +: 32] & ~$past(busWrData)) ==
         ($past(outReg[gw*32 +: 32]) & ~$past(busWrData)))); // R4
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.wrClr && ctrl.word == 8'(gw)) |=>
        ((outReg[gw*32 +: 32] & $past(busWrData)) == 32'd0)); // R5
  end

  // two-bit-per-pin words
  for (genvar ga = 0; ga < ALT_WORDS; ga++) begin : g_alt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        altReg[ga*32 +: 32] <= '0;
      else if (ctrl.wrAlt && ctrl.word == 8'(ga))
        altReg[ga*32 +: 32] <= busWrData;
    end
  end

  // read source select
  always_comb begin
    rdNext = '0;
    case (ctrl.rdSrc)
      SRC_LEVEL: for (int w = 0; w < WORDS; w++)
                   if (ctrl.word == 8'(w)) rdNext = syncB[w*32 +: 32];
      SRC_DIR:   for (int w = 0; w < WORDS; w++)
                   if (ctrl.word == 8'(w)) rdNext = dirReg[w*32 +: 32];
      SRC_ALT:   for (int w = 0; w < ALT_WORDS; w++)
                   if (ctrl.word == 8'(w)) rdNext = altReg[w*32 +: 32];
      SRC_EXT:   rdNext = extRdData;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdReg <= '0;
    else if (ctrl.rdEn) rdReg <= rdNext;
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrDir |=> $stable(dirReg)); // R3
  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdEn && ctrl.rdSrc == SRC_NONE) |=> (rdReg == 32'd0)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.rdEn |=> $stable(rdReg)); // R11

  assign padOut    = outReg;
  assign padOe     = dirReg;
  assign altSel    = altReg;
  assign busRdData = rdReg;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 96,
  parameter int ADDR_W    = 8,
  localparam int WORDS    = PIN_COUNT / 32,
  localparam int WIDX_W   = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  input  logic [PIN_COUNT-1:0]   padIn,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic [2*PIN_COUNT-1:0] altSel,
  output logic                   extWrStb,
  output logic                   extRdStb,
  output logic [1:0]             extType,
  output logic [WIDX_W-1:0]      extWord,
  input  logic [31:0]            extRdData
);

  ctrlStb_t ctrl;

  gpio_bank_decode #(
    .WORDS (WORDS),
    .ADDR_W(ADDR_W),
    .WIDX_W(WIDX_W)
  ) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .ctrl    (ctrl),
    .extWrStb(extWrStb),
    .extRdStb(extRdStb),
    .extType (extType),
    .extWord (extWord)
  );

  gpio_bank_datapath #(
    .PIN_COUNT(PIN_COUNT)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .busWrData(busWrData),
    .extRdData(extRdData),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .altSel   (altSel),
    .busRdData(busRdData)
  );

  AST_EXT_WR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    extWrStb |-> busWrEn); // R9
  AST_EXT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (extWrStb || extRdStb) |-> !(ctrl.wrDir || ctrl.wrSet || ctrl.wrClr || ctrl.wrAlt)); // R9

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;

  localparam int PINS = 96;
  localparam int W    = PINS / 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [PINS-1:0]   padIn = '0;
  logic [PINS-1:0]   padOut;
  logic [PINS-1:0]   padOe;
  logic [2*PINS-1:0] altSel;
  logic              extWrStb;
  logic              extRdStb;
  logic [1:0]        extType;
  logic [1:0]        extWord;
  logic [31:0]       extRdData = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.PIN_COUNT(PINS), .ADDR_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .altSel(altSel),
    .extWrStb(extWrStb), .extRdStb(extRdStb), .extType(extType),
    .extWord(extWord), .extRdData(extRdData)
  );

  function automatic logic [7:0] regAddr(int kind, int word);
    return 8'(kind * W * 4 + word * 4);
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic testReset();
    logic [31:0] r;
    check("R1 padOe", 128'(padOe), 128'd0);
    check("R1 padOut", 128'(padOut), 128'd0);
    check("R1 altSel", 128'(altSel), 128'd0);
    busRead(regAddr(1, 2), r);
    check("R1 dir read", 128'(r), 128'd0);
    busRead(regAddr(7, 5), r);
    check("R1 alt read", 128'(r), 128'd0);
  endtask

  task automatic testDirection();
    logic [31:0] r;
    busWrite(regAddr(1, 0), 32'hA5A5_0001);
    busWrite(regAddr(1, 1), 32'h0000_FF00);
    busWrite(regAddr(1, 2), 32'h8000_0003);
    check("R3 padOe", 128'(padOe), 128'({32'h8000_0003, 32'h0000_FF00, 32'hA5A5_0001}));
    for (int k = 0; k < W; k++) begin
      busRead(regAddr(1, k), r);
      check("R2 dir word", 128'(r), 128'(padOe[k*32 +: 32]));
    end
    busWrite(regAddr(1, 1), 32'h0);
    check("R3 input again", 128'(padOe[32 +: 32]), 128'd0);
  endtask

  task automatic testSetClear();
    logic [31:0] r;
    busWrite(regAddr(2, 1), 32'h0000_00F0);
    check("R4 set", 128'(padOut), 128'({32'h0, 32'h0000_00F0, 32'h0}));
    busWrite(regAddr(2, 2), 32'h8000_0000);
    busWrite(regAddr(2, 1), 32'h0000_0000);
    check("R4 zero no effect", 128'(padOut), 128'({32'h8000_0000, 32'h0000_00F0, 32'h0}));
    busWrite(regAddr(3, 1), 32'h0000_0030);
    check("R5 clear", 128'(padOut), 128'({32'h8000_0000, 32'h0000_00C0, 32'h0}));
    busWrite(regAddr(3, 2), 32'h0);
    check("R5 zero no effect", 128'(padOut[64 +: 32]), 128'(32'h8000_0000));
    busRead(regAddr(2, 1), r);
    check("R6 set reads 0", 128'(r), 128'd0);
    busRead(regAddr(3, 2), r);
    check("R6 clear reads 0", 128'(r), 128'd0);
  endtask

  task automatic testLevel();
    logic [31:0] r;
    @(negedge clk);
    padIn = {32'h1234_5678, 32'h0, 32'hDEAD_BEEF};
    busAddr = regAddr(0, 2); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    check("R7 old level", 128'(busRdData), 128'd0);
    busRead(regAddr(0, 2), r);
    check("R7 new level w2", 128'(r), 128'(32'h1234_5678));
    busRead(regAddr(0, 0), r);
    check("R7 new level w0", 128'(r), 128'(32'hDEAD_BEEF));
    busWrite(regAddr(0, 0), 32'h0);
    busRead(regAddr(0, 0), r);
    check("R7 write ignored", 128'(r), 128'(32'hDEAD_BEEF));
  endtask

  task automatic testAlt();
    logic [31:0] r;
    // pin 37: word 2, bits 11:10
    busWrite(regAddr(7, 2), 32'h0000_0C00);
    check("R8 pin37 field", 128'(altSel[75:74]), 128'd3);
    // pin 95: word 5, bits 31:30
    busWrite(regAddr(7, 5), 32'h8000_0000);
    check("R8 pin95 field", 128'(altSel[191:190]), 128'd2);
    busRead(regAddr(7, 2), r);
    check("R8 readback", 128'(r), 128'(32'h0000_0C00));
    check("R8 others plain", 128'(altSel[73:0]), 128'd0);
  endtask

  task automatic testExt();
    logic [31:0] r;
    @(negedge clk);
    busAddr = regAddr(6, 1); busWrData = 32'h1; busWrEn = 1'b1;
    #1;
    check("R9 wr strobe", 128'({extWrStb, extRdStb, extType, extWord}), 128'({1'b1, 1'b0, 2'd2, 2'd1}));
    @(negedge clk);
    busWrEn = 1'b0;
    check("R9 no dir effect", 128'(padOe[32 +: 32]), 128'd0);
    extRdData = 32'hCAFE_0042;
    @(negedge clk);
    busAddr = regAddr(4, 2); busRdEn = 1'b1;
    #1;
    check("R9 rd strobe", 128'({extWrStb, extRdStb, extType, extWord}), 128'({1'b0, 1'b1, 2'd0, 2'd2}));
    @(negedge clk);
    busRdEn = 1'b0;
    r = busRdData;
    check("R9 read data", 128'(r), 128'(32'hCAFE_0042));
    extRdData = '0;
    repeat (3) @(negedge clk);
    check("R11 hold", 128'(busRdData), 128'(32'hCAFE_0042));
  endtask

  task automatic testUndefined();
    logic [31:0] r;
    logic [PINS-1:0] oeBefore;
    logic [PINS-1:0] outBefore;
    oeBefore = padOe;
    outBefore = padOut;
    busWrite(8'(9 * W * 4), 32'hFFFF_FFFF);
    busWrite(regAddr(1, 0) + 8'd1, 32'hFFFF_FFFF);
    busWrite(regAddr(2, 0) + 8'd2, 32'hFFFF_FFFF);
    check("R10 oe unchanged", 128'(padOe), 128'(oeBefore));
    check("R10 out unchanged", 128'(padOut), 128'(outBefore));
    busRead(8'(9 * W * 4), r);
    check("R10 read beyond", 128'(r), 128'd0);
    busRead(regAddr(1, 0) + 8'd1, r);
    check("R10 misaligned read", 128'(r), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirection();
    testSetClear();
    testLevel();
    testAlt();
    testExt();
    testUndefined();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule